// File: doc/BRIEF.md
# Error Interrupt and RAS Classifier

This block gathers the error event lines of an accelerator datapath into a sticky source register. An event stays recorded until software clears it. A per-bit mask decides which recorded errors reach the interrupt line. Three class-enable registers sort the unmasked errors into correctable, non-fatal and fatal classes, and each class drives its own output. Software can also inject any error through a set register, which lets the reporting path be exercised without a datapath fault.

A control bit arms a bus-master stop. While it is armed, any active error of the non-fatal class raises a shutdown request for the bus master. The request holds until two things have happened: the non-fatal errors are gone, and the arm bit has been written low. When a multi-bit ECC event occurs, the block also records the failing SRAM number and address.

Registers sit on a simple 32-bit bus. Writes are single-cycle strobes and reads are combinational with no side effects. Register offsets are bytes: 0x00 source, 0x04 mask, 0x08 set, 0x0C status, 0x10 correctable enable, 0x14 non-fatal enable, 0x18 fatal enable, 0x1C control, 0x20 ECC info. The error bits are 0 to 12. Bit 0 is the single-bit ECC error and bit 1 is the multi-bit ECC error.

Top module: `ras_err_ctrl`

## Requirements
- R1: An error event on bit i (0..12) sets bit i of the source register (read at 0x00) at the next clock edge, and the bit stays set after the event goes away.
- R2: A write to 0x00 clears exactly the source bits written as 1. Writing 0x1FFF clears all of them, and bits written as 0 are kept.
- R3: When a hardware event and a clearing write hit the same source bit in the same cycle, the bit stays set.
- R4: The mask register (0x04) resets to 0x1FFF. A mask bit of 1 blocks that error. The status register (0x0C) reads as source AND NOT mask, and irq is high whenever status is nonzero.
- R5: Writing 1s to the set register (0x08) sets those source bits as if hardware had raised them. The set register always reads 0.
- R6: The class enables reset to these values: correctable (0x10) = 0x1, non-fatal (0x14) = 0x1FFE, fatal (0x18) = 0x0.
- R7: The outputs ce, nfe and fe are each high when status AND the matching class enable is nonzero.
- R8: With control bit 14 (0x1C) set, an active non-fatal-class error raises shutdown_req at the following clock edge. Errors of the other classes do not raise it.
- R9: Once raised, shutdown_req holds until there is no non-fatal-class error and control bit 14 is 0. It then drops at the next edge, and setting bit 14 again does not raise it.
- R10: A hardware event on bit 1 captures the SRAM number into bits 23:16 and the SRAM address into bits 31:24 of the ECC info register (0x20). An injected bit 1 captures nothing.
- R11: Register bits above bit 12, control bits other than bit 14, and unmapped offsets all read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 13 | Per-bit hardware error events |
| ecc_num_i | input | 8 | SRAM number of a multi-bit ECC error |
| ecc_addr_i | input | 8 | SRAM address of a multi-bit ECC error |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data at bus_addr_i |
| irq_o | output | 1 | Any unmasked error |
| ce_o | output | 1 | Correctable-class error active |
| nfe_o | output | 1 | Non-fatal-class error active |
| fe_o | output | 1 | Fatal-class error active |
| shutdown_req_o | output | 1 | Bus-master stop request |

## Verification
The class and interrupt outputs are combinational functions of the stored source, mask and enables. A wrong source bit or a wrong configuration value therefore shows at irq, ce, nfe or fe in the same cycle that its effect is unmasked, and a register read shows it at once. Shutdown state that is wrong appears one edge later, as a request that rises without cause, or one that fails to hold or fails to release. A reference model in the bench predicts every output every cycle, so a divergence is reported in the cycle where it first becomes visible.

// File: rtl/ras_err_pkg.sv
package ras_err_pkg;
    // byte offsets of the register file
    localparam int OFS_SRC  = 'h00;
    localparam int OFS_MASK = 'h04;
    localparam int OFS_SET  = 'h08;
    localparam int OFS_STAT = 'h0C;
    localparam int OFS_CE   = 'h10;
    localparam int OFS_NFE  = 'h14;
    localparam int OFS_FE   = 'h18;
    localparam int OFS_CTRL = 'h1C;
    localparam int OFS_ECC  = 'h20;

    localparam int REG_W        = 32;
    localparam int SD_EN_BIT    = 14;
    localparam int ECC_BIT      = 1;
    localparam int ECC_NUM_LSB  = 16;
    localparam int ECC_ADDR_LSB = 24;

    // class index order used by the router
    localparam int CLS_CE  = 0;
    localparam int CLS_NFE = 1;
    localparam int CLS_FE  = 2;
    localparam int NUM_CLS = 3;
endpackage

// File: rtl/ras_err_source.sv
module ras_err_source #(
    parameter int NUM_ERR = 13
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_ERR-1:0] evt_i,
    input  logic [NUM_ERR-1:0] clr_i,
    input  logic [NUM_ERR-1:0] inj_i,
    output logic [NUM_ERR-1:0] src_o
);
    logic [NUM_ERR-1:0] src_d, src_q;

    // raising terms are applied after the clear so an event beats a clear
    always_comb begin
        src_d = (src_q & ~clr_i) | evt_i | inj_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) src_q <= '0;
        else         src_q <= src_d;
    end

    assign src_o = src_q;

    // R1 R3
    evt_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));

    // R2
    clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|clr_i) && !(|(evt_i | inj_i))) |=> ((src_q & $past(clr_i)) == '0));
endmodule

// File: rtl/ras_err_router.sv
module ras_err_router #(
    parameter int NUM_ERR = 13,
    parameter int NUM_CLS = 3
) (
    input  logic [NUM_ERR-1:0]              status_i,
    input  logic [NUM_CLS-1:0][NUM_ERR-1:0] en_i,
    output logic [NUM_CLS-1:0]              hit_o
);
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign hit_o[c] = |(status_i & en_i[c]);
    end
endmodule

// File: rtl/ras_err_shutdown.sv
module ras_err_shutdown (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic nfe_i,
    output logic req_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (arm_i && nfe_i)        req_d = 1'b1;
        else if (!arm_i && !nfe_i) req_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= req_d;
    end

    assign req_o = req_q;

    // R8
    sd_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_q) |-> $past(arm_i && nfe_i));

    // R9
    sd_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(req_q) |-> $past(!arm_i && !nfe_i));
endmodule

// File: rtl/ras_err_ctrl.sv
module ras_err_ctrl
    import ras_err_pkg::*;
#(
    parameter int NUM_ERR    = 13,
    parameter int ADDR_W     = 8,
    parameter int ECC_NUM_W  = 8,
    parameter int ECC_ADDR_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_ERR-1:0]    err_evt_i,
    input  logic [ECC_NUM_W-1:0]  ecc_num_i,
    input  logic [ECC_ADDR_W-1:0] ecc_addr_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [REG_W-1:0]      bus_wdata_i,
    output logic [REG_W-1:0]      bus_rdata_o,
    output logic                  irq_o,
    output logic                  ce_o,
    output logic                  nfe_o,
    output logic                  fe_o,
    output logic                  shutdown_req_o
);
    localparam logic [NUM_ERR-1:0] ALL_ERR = '1;
    localparam logic [NUM_ERR-1:0] CE_RST  = NUM_ERR'(1);
    localparam logic [NUM_ERR-1:0] NFE_RST = ALL_ERR & ~CE_RST;
    localparam logic [ADDR_W-1:0]  A_SRC   = ADDR_W'(OFS_SRC);
    localparam logic [ADDR_W-1:0]  A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0]  A_SET   = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0]  A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0]  A_CE    = ADDR_W'(OFS_CE);
    localparam logic [ADDR_W-1:0]  A_NFE   = ADDR_W'(OFS_NFE);
    localparam logic [ADDR_W-1:0]  A_FE    = ADDR_W'(OFS_FE);
    localparam logic [ADDR_W-1:0]  A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0]  A_ECC   = ADDR_W'(OFS_ECC);

    typedef struct packed {
        logic [NUM_ERR-1:0]    mask;
        logic [NUM_ERR-1:0]    ce_en;
        logic [NUM_ERR-1:0]    nfe_en;
        logic [NUM_ERR-1:0]    fe_en;
        logic                  sd_en;
        logic [ECC_NUM_W-1:0]  ecc_num;
        logic [ECC_ADDR_W-1:0] ecc_addr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_ERR-1:0]              src_clr, src_inj, src, status;
    logic [NUM_CLS-1:0][NUM_ERR-1:0] cls_en;
    logic [NUM_CLS-1:0]              cls_hit;
    logic                            unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    assign src_clr = (bus_wr_i && bus_addr_i == A_SRC) ? bus_wdata_i[NUM_ERR-1:0] : '0;
    assign src_inj = (bus_wr_i && bus_addr_i == A_SET) ? bus_wdata_i[NUM_ERR-1:0] : '0;

    ras_err_source #(.NUM_ERR(NUM_ERR)) u_src (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (err_evt_i),
        .clr_i  (src_clr),
        .inj_i  (src_inj),
        .src_o  (src)
    );

    assign status = src & ~cfg_q.mask;
    assign cls_en = {cfg_q.fe_en, cfg_q.nfe_en, cfg_q.ce_en};

    ras_err_router #(.NUM_ERR(NUM_ERR), .NUM_CLS(NUM_CLS)) u_route (
        .status_i (status),
        .en_i     (cls_en),
        .hit_o    (cls_hit)
    );

    ras_err_shutdown u_sd (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (cfg_q.sd_en),
        .nfe_i  (cls_hit[CLS_NFE]),
        .req_o  (shutdown_req_o)
    );

    // next-state of the configuration and capture registers
    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                A_MASK:  cfg_d.mask   = bus_wdata_i[NUM_ERR-1:0];
                A_CE:    cfg_d.ce_en  = bus_wdata_i[NUM_ERR-1:0];
                A_NFE:   cfg_d.nfe_en = bus_wdata_i[NUM_ERR-1:0];
                A_FE:    cfg_d.fe_en  = bus_wdata_i[NUM_ERR-1:0];
                A_CTRL:  cfg_d.sd_en  = bus_wdata_i[SD_EN_BIT];
                default: ;
            endcase
        end
        if (err_evt_i[ECC_BIT]) begin
            cfg_d.ecc_num  = ecc_num_i;
            cfg_d.ecc_addr = ecc_addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.mask     <= ALL_ERR;
            cfg_q.ce_en    <= CE_RST;
            cfg_q.nfe_en   <= NFE_RST;
            cfg_q.fe_en    <= '0;
            cfg_q.sd_en    <= 1'b0;
            cfg_q.ecc_num  <= '0;
            cfg_q.ecc_addr <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_SRC:   bus_rdata_o[NUM_ERR-1:0] = src;
            A_MASK:  bus_rdata_o[NUM_ERR-1:0] = cfg_q.mask;
            A_STAT:  bus_rdata_o[NUM_ERR-1:0] = status;
            A_CE:    bus_rdata_o[NUM_ERR-1:0] = cfg_q.ce_en;
            A_NFE:   bus_rdata_o[NUM_ERR-1:0] = cfg_q.nfe_en;
            A_FE:    bus_rdata_o[NUM_ERR-1:0] = cfg_q.fe_en;
            A_CTRL:  bus_rdata_o[SD_EN_BIT]   = cfg_q.sd_en;
            A_ECC: begin
                bus_rdata_o[ECC_NUM_LSB +: ECC_NUM_W]   = cfg_q.ecc_num;
                bus_rdata_o[ECC_ADDR_LSB +: ECC_ADDR_W] = cfg_q.ecc_addr;
            end
            default: ;
        endcase
    end

    assign irq_o = |status;
    assign ce_o  = cls_hit[CLS_CE];
    assign nfe_o = cls_hit[CLS_NFE];
    assign fe_o  = cls_hit[CLS_FE];

    // R4
    mask_all_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_MASK && bus_wdata_i[NUM_ERR-1:0] == ALL_ERR)
        |=> !irq_o);

    // R7
    class_implies_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_o || nfe_o || fe_o) |-> irq_o);

    // R10
    ecc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_evt_i[ECC_BIT] |=> (cfg_q.ecc_num == $past(ecc_num_i)
                                && cfg_q.ecc_addr == $past(ecc_addr_i)));
endmodule

// File: tb/tb_ras_err_ctrl.sv
`timescale 1ns/1ps
module tb_ras_err_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt = '0;
    logic [7:0]  num_in = '0, adr_in = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, ce, nfe, fe, sd;

    always #2.5 clk = ~clk;

    ras_err_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .err_evt_i(evt),
        .ecc_num_i(num_in), .ecc_addr_i(adr_in),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .ce_o(ce), .nfe_o(nfe),
        .fe_o(fe), .shutdown_req_o(sd)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [12:0] m_src = '0, m_mask = 13'h1FFF, m_ce = 13'h1, m_nfe = 13'h1FFE, m_fe = '0;
    logic        m_en = 1'b0, m_sd = 1'b0;
    logic [7:0]  m_num = '0, m_adr = '0;
    logic [12:0] t_st, t_clr, t_inj;
    logic        t_nh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = '0; m_mask = 13'h1FFF; m_ce = 13'h1; m_nfe = 13'h1FFE; m_fe = '0;
            m_en = 1'b0; m_sd = 1'b0; m_num = '0; m_adr = '0;
        end else begin
            t_st = m_src & ~m_mask;
            t_nh = |(t_st & m_nfe);
            if (m_en && t_nh) m_sd = 1'b1;
            else if (!m_en && !t_nh) m_sd = 1'b0;
            t_clr = (wr && addr == 8'h00) ? wdata[12:0] : 13'h0;
            t_inj = (wr && addr == 8'h08) ? wdata[12:0] : 13'h0;
            m_src = (m_src & ~t_clr) | evt | t_inj;
            if (wr) begin
                case (addr)
                    8'h04: m_mask = wdata[12:0];
                    8'h10: m_ce   = wdata[12:0];
                    8'h14: m_nfe  = wdata[12:0];
                    8'h18: m_fe   = wdata[12:0];
                    8'h1C: m_en   = wdata[14];
                    default: ;
                endcase
            end
            if (evt[1]) begin m_num = num_in; m_adr = adr_in; end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return {19'h0, m_src};
            8'h04: return {19'h0, m_mask};
            8'h0C: return {19'h0, m_src & ~m_mask};
            8'h10: return {19'h0, m_ce};
            8'h14: return {19'h0, m_nfe};
            8'h18: return {19'h0, m_fe};
            8'h1C: return {17'h0, m_en, 14'h0};
            8'h20: return {m_adr, m_num, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [12:0] st;
        st = m_src & ~m_mask;
        chk("R4 irq", {31'h0, irq}, {31'h0, |st});
        chk("R7 ce",  {31'h0, ce},  {31'h0, |(st & m_ce)});
        chk("R7 nfe", {31'h0, nfe}, {31'h0, |(st & m_nfe)});
        chk("R7 fe",  {31'h0, fe},  {31'h0, |(st & m_fe)});
        chk("R9 shutdown", {31'h0, sd}, {31'h0, m_sd});
        chk("R11 rdata", rdata, exp_rd(addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_w(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [12:0] v);
        evt = v;
        tick();
        evt = '0;
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        peek(8'h04, 32'h1FFF, "R4 mask reset");
        peek(8'h10, 32'h1, "R6 ce reset");
        peek(8'h14, 32'h1FFE, "R6 nfe reset");
        peek(8'h18, 32'h0, "R6 fe reset");
        peek(8'h00, 32'h0, "R1 source reset");
        chk("R4 irq reset", {31'h0, irq}, 32'h0);
        chk("R8 shutdown reset", {31'h0, sd}, 32'h0);
        // sticky latch while masked
        pulse(13'h020);
        tick();
        peek(8'h00, 32'h20, "R1 sticky");
        chk("R4 masked irq", {31'h0, irq}, 32'h0);
        // unmask
        bus_w(8'h04, 32'h0);
        chk("R4 unmasked irq", {31'h0, irq}, 32'h1);
        chk("R7 nfe class", {31'h0, nfe}, 32'h1);
        chk("R7 ce class", {31'h0, ce}, 32'h0);
        peek(8'h0C, 32'h20, "R4 status");
        // arm shutdown
        bus_w(8'h1C, 32'h4000);
        tick();
        chk("R8 shutdown raised", {31'h0, sd}, 32'h1);
        // clear error, request holds
        bus_w(8'h00, 32'h20);
        peek(8'h00, 32'h0, "R2 clear");
        tick();
        chk("R9 held", {31'h0, sd}, 32'h1);
        bus_w(8'h1C, 32'h0);
        tick();
        chk("R9 released", {31'h0, sd}, 32'h0);
        bus_w(8'h1C, 32'h4000);
        tick();
        chk("R9 stays low", {31'h0, sd}, 32'h0);
        // event and clear in the same cycle
        pulse(13'h001);
        evt = 13'h001;
        bus_w(8'h00, 32'h1);
        evt = '0;
        peek(8'h00, 32'h1, "R3 event wins");
        chk("R7 ce active", {31'h0, ce}, 32'h1);
        tick();
        chk("R8 no shutdown for ce", {31'h0, sd}, 32'h0);
        // reroute bit 12 to fatal, then inject it
        bus_w(8'h14, 32'h0FFE);
        bus_w(8'h18, 32'h1000);
        bus_w(8'h08, 32'h1000);
        peek(8'h00, 32'h1001, "R5 inject");
        peek(8'h08, 32'h0, "R5 set reads zero");
        chk("R7 fatal", {31'h0, fe}, 32'h1);
        chk("R7 nfe off", {31'h0, nfe}, 32'h0);
        peek(8'h20, 32'h0, "R10 no capture on inject");
        // ECC capture
        num_in = 8'hA5; adr_in = 8'h3C;
        pulse(13'h002);
        num_in = '0; adr_in = '0;
        peek(8'h20, 32'h3CA5_0000, "R10 ecc info");
        tick();
        chk("R8 shutdown on ecc", {31'h0, sd}, 32'h1);
        // clear all, partial clear
        bus_w(8'h00, 32'h1FFF);
        peek(8'h00, 32'h0, "R2 clear all");
        pulse(13'h003);
        bus_w(8'h00, 32'h1);
        peek(8'h00, 32'h2, "R2 partial clear");
        // widths and unmapped
        peek(8'h40, 32'h0, "R11 unmapped");
        bus_w(8'h1C, 32'hFFFF_FFFF);
        peek(8'h1C, 32'h4000, "R11 ctrl bits");
        bus_w(8'h04, 32'hFFFF_FFFF);
        peek(8'h04, 32'h1FFF, "R11 mask width");
        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            evt    = (($urandom % 4) == 0) ? 13'($urandom) : 13'h0;
            num_in = 8'($urandom);
            adr_in = 8'($urandom);
            if (($urandom % 3) == 0) begin
                wr = 1'b1;
                case ($urandom % 8)
                    0: addr = 8'h00;
                    1: addr = 8'h04;
                    2: addr = 8'h08;
                    3: addr = 8'h10;
                    4: addr = 8'h14;
                    5: addr = 8'h18;
                    6: addr = 8'h1C;
                    default: addr = 8'h20;
                endcase
                wdata = $urandom;
            end else begin
                wr = 1'b0;
                addr = 8'(($urandom % 10) * 4);
            end
            tick();
        end
        wr = 1'b0; evt = '0;
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule